// File: doc/BRIEF.md
# Pixel Pack, Expand and Merge Unit

This block reformats pixel data held in 64-bit operands. It has three kinds of operation. The pack operations take signed fixed-point lanes and scale each one left by an amount from the scale field of a graphics status register. A fixed right shift follows, and the value is clamped either to an unsigned byte or to a signed 16-bit value. The expand operation widens unsigned bytes into 16-bit fixed-point lanes. The merge operation interleaves the bytes of two 32-bit words. One of the pack modes also moves the previous pixel word up by one byte, so that a newly clamped pixel can be appended at the bottom of each 32-bit half.

The datapath is combinational. Its result is captured in an output register on the clock edge at which the input strobe `inValid` is high. One cycle later an output-valid pulse accompanies the result. A second output flag marks results in which only the low 32 bits carry data. Operation codes outside the five defined ones give a zero result and raise an illegal-operation flag.

Top module: `pixfmt_unit`

## Requirements
- R1: With `opSel`=0, each signed 16-bit lane i of `srcB` is shifted left by `statusScale[6:3]` (bit 7 has no effect) and then arithmetically right by 7. It is clamped to 0..255 and placed in `result[8i+7:8i]`. `result[63:32]` is zero and `narrowOut` is 1.
- R2: With `opSel`=1, each signed 32-bit lane i of `srcB` is shifted left by `statusScale[7:3]` and then arithmetically right by 23. It is clamped to 0..255 and placed in `result[32i+7:32i]`. `narrowOut` is 0.
- R3: With `opSel`=1, all bits of the result other than the two clamped bytes equal `srcA` shifted left by 8 bits. That is, `result[31:8]`=`srcA[23:0]` and `result[63:40]`=`srcA[55:32]`.
- R4: With `opSel`=2, each signed 32-bit lane i of `srcB` is shifted left by `statusScale[7:3]` and then arithmetically right by 16. It is saturated to -32768..32767 and placed in `result[16i+15:16i]`. `result[63:32]` is zero and `narrowOut` is 1.
- R5: With `opSel`=3, each byte i of `srcB[31:0]` is shifted left by 4 and zero-extended into `result[16i+15:16i]`, which puts zeros in bits [3:0] and [15:12] of every lane. `narrowOut` is 0.
- R6: With `opSel`=4, `result` holds, from the least significant byte upward, `srcB` byte 0, `srcA` byte 0, `srcB` byte 1, `srcA` byte 1, and so on through byte 3. `narrowOut` is 0.
- R7: At the largest scale (31 for the 32-bit lane modes, 15 for the 16-bit mode), no intermediate value wraps. Large positive lanes clamp to the upper bound and large negative lanes clamp to the lower bound.
- R8: With `opSel` 5, 6 or 7, `result` is zero, `illegalOp` is 1 and `narrowOut` is 0. For codes 0 to 4, `illegalOp` is 0.
- R9: Results appear one cycle after `inValid` is high. `outValid` is 1 for exactly the cycle after each strobe. While `inValid` is low, `result`, `narrowOut` and `illegalOp` keep their values.
- R10: After reset, `outValid`, `result`, `narrowOut` and `illegalOp` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Strobe that captures an operation |
| opSel | input | 3 | Operation: 0 pack16, 1 pack32, 2 fixed pack, 3 expand, 4 merge |
| srcA | input | 64 | First operand |
| srcB | input | 64 | Second operand |
| statusScale | input | 5 (bits 7:3) | Scale field of the graphics status register |
| outValid | output | 1 | Result valid pulse |
| result | output | 64 | Formatted result |
| narrowOut | output | 1 | Only `result[31:0]` is meaningful |
| illegalOp | output | 1 | Last captured code was undefined |

## Verification
Several properties are checked on every cycle:
- the one-cycle valid timing;
- holding of the result while idle;
- zeroing on undefined codes;
- the zero upper half whenever the narrow flag is set;
- the zero nibbles of expanded lanes;
- the low bytes of a merge;
- the shifted previous word in the 32-bit pack.

The arithmetic of the pack modes can only be shown by the bench's scenarios. These are scaling, the arithmetic right shift and clamping at both bounds, including the largest scale, where a narrow intermediate would wrap. The bench also shows that bit 7 of the scale field is ignored by the 16-bit pack.

// File: rtl/pixfmt_pkg.sv
package pixfmt_pkg;
  localparam int OP_W      = 3;
  localparam int SCALE_LSB = 3;
  localparam int SCALE16_W = 4;
  localparam int SCALE32_W = 5;
  localparam int STAT_W    = SCALE_LSB + SCALE32_W;
  localparam int WIDE_W    = 64;
  localparam int RSH16     = 7;
  localparam int RSH32     = 23;
  localparam int RSHFIX    = 16;

  typedef enum logic [OP_W-1:0] {
    OP_PACK16  = 3'd0,
    OP_PACK32  = 3'd1,
    OP_PACKFIX = 3'd2,
    OP_EXPAND  = 3'd3,
    OP_MERGE   = 3'd4
  } pixOp_e;

  typedef struct packed {
    logic   load;
    logic   illegal;
    logic   narrow;
    pixOp_e sel;
  } pixStrobe_t;

  function automatic logic [7:0] clampU8(input logic signed [WIDE_W-1:0] v);
    if (v < 0)        return 8'd0;
    else if (v > 255) return 8'd255;
    else              return v[7:0];
  endfunction

  function automatic logic [15:0] clampS16(input logic signed [WIDE_W-1:0] v);
    if (v < -32768)     return 16'h8000;
    else if (v > 32767) return 16'h7fff;
    else                return v[15:0];
  endfunction
endpackage

// File: rtl/pixfmt_ctrl.sv
module pixfmt_ctrl
  import pixfmt_pkg::*;
(
  input  logic            inValid,
  input  logic [OP_W-1:0] opSel,
  output pixStrobe_t      strobe
);
  always_comb begin
    strobe.load    = inValid;
    strobe.illegal = 1'b0;
    strobe.narrow  = 1'b0;
    strobe.sel     = OP_PACK16;
    case (opSel)
      3'd0: begin strobe.sel = OP_PACK16;  strobe.narrow = 1'b1; end
      3'd1: strobe.sel = OP_PACK32;
      3'd2: begin strobe.sel = OP_PACKFIX; strobe.narrow = 1'b1; end
      3'd3: strobe.sel = OP_EXPAND;
      3'd4: strobe.sel = OP_MERGE;
      default: strobe.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/pixfmt_datapath.sv
module pixfmt_datapath
  import pixfmt_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  pixStrobe_t                  strobe,
  input  logic [DATA_W-1:0]           srcA,
  input  logic [DATA_W-1:0]           srcB,
  input  logic [STAT_W-1:SCALE_LSB]   statusScale,
  output logic                        outValid,
  output logic [DATA_W-1:0]           result,
  output logic                        narrowOut,
  output logic                        illegalOp
);
  localparam int HALF_W = DATA_W / 2;
  localparam int N16    = DATA_W / 16;
  localparam int N32    = DATA_W / 32;
  localparam int NBYTE  = HALF_W / 8;

  logic [SCALE16_W-1:0] scale16;
  logic [SCALE32_W-1:0] scale32;
  assign scale16 = statusScale[SCALE_LSB+SCALE16_W-1:SCALE_LSB];
  assign scale32 = statusScale;

  logic [DATA_W-1:0] pack16Res, pack32Res, fixRes, expandRes, mergeRes;
  logic [N32-1:0][7:0] pack32Lane;

  assign pack16Res[DATA_W-1:HALF_W] = '0;
  assign fixRes[DATA_W-1:HALF_W]    = '0;

  for (genvar g = 0; g < N16; g++) begin : gLane16
    logic signed [WIDE_W-1:0] ext16, sh16;
    always_comb begin
      ext16 = {{(WIDE_W-16){srcB[16*g+15]}}, srcB[16*g +: 16]};
      sh16  = (ext16 <<< scale16) >>> RSH16;
    end
    assign pack16Res[8*g +: 8] = clampU8(sh16);
  end

  for (genvar g = 0; g < N32; g++) begin : gLane32
    logic signed [WIDE_W-1:0] ext32, scaled32, shPix, shFix;
    always_comb begin
      ext32    = {{(WIDE_W-32){srcB[32*g+31]}}, srcB[32*g +: 32]};
      scaled32 = ext32 <<< scale32;
      shPix    = scaled32 >>> RSH32;
      shFix    = scaled32 >>> RSHFIX;
    end
    assign pack32Lane[g]         = clampU8(shPix);
    assign fixRes[16*g +: 16]    = clampS16(shFix);
  end

  always_comb begin
    pack32Res = srcA << 8;
    for (int i = 0; i < N32; i++) begin
      pack32Res[32*i +: 8] = pack32Lane[i];
    end
  end

  for (genvar g = 0; g < NBYTE; g++) begin : gByte
    assign expandRes[16*g +: 16] = {4'b0000, srcB[8*g +: 8], 4'b0000};
    assign mergeRes[16*g +: 16]  = {srcA[8*g +: 8], srcB[8*g +: 8]};
  end

  logic [DATA_W-1:0] selRes;
  always_comb begin
    unique case (strobe.sel)
      OP_PACK16:  selRes = pack16Res;
      OP_PACK32:  selRes = pack32Res;
      OP_PACKFIX: selRes = fixRes;
      OP_EXPAND:  selRes = expandRes;
      OP_MERGE:   selRes = mergeRes;
      default:    selRes = '0;
    endcase
    if (strobe.illegal) selRes = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      result    <= '0;
      narrowOut <= 1'b0;
      illegalOp <= 1'b0;
    end else begin
      outValid <= strobe.load;
      if (strobe.load) begin
        result    <= selRes;
        narrowOut <= strobe.narrow;
        illegalOp <= strobe.illegal;
      end
    end
  end
endmodule

// File: rtl/pixfmt_unit.sv
module pixfmt_unit
  import pixfmt_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inValid,
  input  logic [OP_W-1:0]           opSel,
  input  logic [DATA_W-1:0]         srcA,
  input  logic [DATA_W-1:0]         srcB,
  input  logic [STAT_W-1:SCALE_LSB] statusScale,
  output logic                      outValid,
  output logic [DATA_W-1:0]         result,
  output logic                      narrowOut,
  output logic                      illegalOp
);
  pixStrobe_t strobe;

  pixfmt_ctrl u_ctrl (
    .inValid (inValid),
    .opSel   (opSel),
    .strobe  (strobe)
  );

  pixfmt_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .srcA        (srcA),
    .srcB        (srcB),
    .statusScale (statusScale),
    .outValid    (outValid),
    .result      (result),
    .narrowOut   (narrowOut),
    .illegalOp   (illegalOp)
  );
endmodule

// File: rtl/pixfmt_checker.sv
module pixfmt_checker (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [2:0]  opSel,
  input logic [63:0] srcA,
  input logic [63:0] srcB,
  input logic        outValid,
  input logic [63:0] result,
  input logic        narrowOut,
  input logic        illegalOp
);
  assert_valid_latency_R9: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(result) && $stable(narrowOut) && $stable(illegalOp)));

  assert_illegal_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel > 3'd4) |=> (illegalOp && result == 64'd0 && !narrowOut));

  assert_legal_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel <= 3'd4) |=> !illegalOp);

  // R1 and R4: narrow results leave the upper half clear
  assert_narrow_upper_R4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && narrowOut) |-> (result[63:32] == 32'd0));

  assert_expand_nibbles_R5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 3'd3) |=> ((result & 64'hF00F_F00F_F00F_F00F) == 64'd0));

  assert_merge_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 3'd4) |=> (result[15:0] == {$past(srcA[7:0]), $past(srcB[7:0])}));

  assert_pack32_shift_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 3'd1) |=>
      (result[31:8] == $past(srcA[23:0]) && result[63:40] == $past(srcA[55:32])));
endmodule

bind pixfmt_unit pixfmt_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .opSel     (opSel),
  .srcA      (srcA),
  .srcB      (srcB),
  .outValid  (outValid),
  .result    (result),
  .narrowOut (narrowOut),
  .illegalOp (illegalOp)
);

// File: tb/tb_pixfmt_unit.sv
module tb_pixfmt_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  opSel = 3'd0;
  logic [63:0] srcA = '0;
  logic [63:0] srcB = '0;
  logic [7:0]  stat = '0;
  logic        outValid, narrowOut, illegalOp;
  logic [63:0] result;

  int nChecks = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  pixfmt_unit dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .srcA(srcA), .srcB(srcB), .statusScale(stat[7:3]),
    .outValid(outValid), .result(result), .narrowOut(narrowOut), .illegalOp(illegalOp)
  );

  function automatic longint clampLong(longint v, longint lo, longint hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic logic [63:0] mdlPack16(logic [63:0] b, logic [7:0] s);
    logic [63:0] r = '0;
    longint v;
    for (int i = 0; i < 4; i++) begin
      v = longint'($signed(b[16*i +: 16]));
      v = (v <<< s[6:3]) >>> 7;
      v = clampLong(v, 0, 255);
      r[8*i +: 8] = v[7:0];
    end
    return r;
  endfunction

  function automatic logic [63:0] mdlPack32(logic [63:0] a, logic [63:0] b, logic [7:0] s);
    logic [63:0] r = a << 8;
    longint v;
    for (int i = 0; i < 2; i++) begin
      v = longint'($signed(b[32*i +: 32]));
      v = (v <<< s[7:3]) >>> 23;
      v = clampLong(v, 0, 255);
      r[32*i +: 8] = v[7:0];
    end
    return r;
  endfunction

  function automatic logic [63:0] mdlFix(logic [63:0] b, logic [7:0] s);
    logic [63:0] r = '0;
    longint v;
    for (int i = 0; i < 2; i++) begin
      v = longint'($signed(b[32*i +: 32]));
      v = (v <<< s[7:3]) >>> 16;
      v = clampLong(v, -32768, 32767);
      r[16*i +: 16] = v[15:0];
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runOp(logic [2:0] op, logic [63:0] a, logic [63:0] b, logic [7:0] s);
    @(negedge clk);
    inValid = 1'b1; opSel = op; srcA = a; srcB = b; stat = s;
    @(negedge clk);
    inValid = 1'b0;
    chk("R9 outValid after strobe", {63'd0, outValid}, 64'd1);
  endtask

  task automatic testReset;
    chk("R10 reset result", result, 64'd0);
    chk("R10 reset flags", {61'd0, outValid, narrowOut, illegalOp}, 64'd0);
  endtask

  task automatic testPack16;
    logic [63:0] b = 64'h0100_7FFF_FFFF_0080;
    runOp(3'd0, 64'hFFFF_FFFF_FFFF_FFFF, b, 8'h8F);
    chk("R1 pack16 scale1 bit7 ignored", result, mdlPack16(b, 8'h0F));
    chk("R1 pack16 narrow", {63'd0, narrowOut}, 64'd1);
    runOp(3'd0, 64'd0, 64'h1234_8000_0040_3FFF, 8'h00);
    chk("R1 pack16 scale0", result, mdlPack16(64'h1234_8000_0040_3FFF, 8'h00));
  endtask

  task automatic testPack32;
    logic [63:0] a = 64'h1122_3344_5566_7788;
    runOp(3'd1, a, 64'h0002_4000_0001_8000, 8'h40);
    chk("R2 R3 pack32 scale8", result, mdlPack32(a, 64'h0002_4000_0001_8000, 8'h40));
    chk("R2 pack32 wide", {63'd0, narrowOut}, 64'd0);
    runOp(3'd1, a, 64'h8000_0000_7FFF_FFFF, 8'h00);
    chk("R2 pack32 clamp", result, 64'h2233_4400_6677_88FF);
  endtask

  task automatic testFix;
    runOp(3'd2, 64'd0, 64'h0001_2345_FFFE_0000, 8'h00);
    chk("R4 fix scale0", result, 64'h0000_0000_0001_FFFE);
    chk("R4 fix narrow", {63'd0, narrowOut}, 64'd1);
    runOp(3'd2, 64'd0, 64'h4000_0000_C000_0000, 8'h20);
    chk("R4 fix saturate", result, mdlFix(64'h4000_0000_C000_0000, 8'h20));
  endtask

  task automatic testMaxScale;
    runOp(3'd1, 64'd0, 64'h0000_0001_FFFF_FFFF, 8'hF8);
    chk("R7 pack32 scale31", result, 64'h0000_00FF_0000_0000);
    runOp(3'd2, 64'd0, 64'h7FFF_FFFF_8000_0001, 8'hF8);
    chk("R7 fix scale31", result, 64'h0000_0000_7FFF_8000);
    runOp(3'd0, 64'd0, 64'h0001_FFFF_0001_FFFF, 8'h78);
    chk("R7 pack16 scale15", result, 64'h0000_0000_FF00_FF00);
  endtask

  task automatic testExpand;
    runOp(3'd3, 64'h0, 64'hDEAD_BEEF_A5C3_0FF0, 8'hFF);
    chk("R5 expand", result, 64'h0A50_0C30_00F0_0F00);
    chk("R5 expand wide", {62'd0, narrowOut, illegalOp}, 64'd0);
  endtask

  task automatic testMerge;
    runOp(3'd4, 64'h1111_1111_A3A2_A1A0, 64'h2222_2222_B3B2_B1B0, 8'h00);
    chk("R6 merge", result, 64'hA3B3_A2B2_A1B1_A0B0);
    chk("R6 merge flags", {62'd0, narrowOut, illegalOp}, 64'd0);
  endtask

  task automatic testIllegal;
    for (int op = 5; op < 8; op++) begin
      runOp(3'(op), 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_7FFF_7FFF_7FFF, 8'h08);
      chk("R8 illegal result", result, 64'd0);
      chk("R8 illegal flags", {62'd0, illegalOp, narrowOut}, 64'd2);
    end
  endtask

  task automatic testHold;
    logic [63:0] held;
    runOp(3'd4, 64'h0000_0000_0102_0304, 64'h0000_0000_0506_0708, 8'h00);
    held = result;
    @(negedge clk);
    chk("R9 outValid pulse ends", {63'd0, outValid}, 64'd0);
    srcA = '1; srcB = '1; opSel = 3'd0; stat = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R9 result held while idle", result, held);
    chk("R9 flags held while idle", {62'd0, narrowOut, illegalOp}, 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPack16();
    testPack32();
    testFix();
    testMaxScale();
    testExpand();
    testMerge();
    testIllegal();
    testHold();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule